// File: doc/BRIEF.md
# Pixel Hit Timestamp Buffer

This block sits behind the discriminator of one pixel in a binary-readout sensor that runs on a bunch-train beam structure. A train-start strobe opens a capture window. From then on, every collision strobe advances a collision counter. When the discriminator bit is high on a collision, the counter value is written into a small local store as a timestamp. The window closes by itself after the last collision of the train. Collisions without a hit store nothing, so the store holds only the hit times.

In the dead time between trains, a readout enable starts the serialiser. It sends the stored timestamps in capture order over a valid/ready handshake, and then sends one marker word that carries the hit count and an overflow bit. A hit that arrives when the store is full is dropped and sets a sticky overflow flag. A mask bit, written only while the block is idle, silences a bad pixel: a masked pixel records nothing, keeps its comparator power-enable low and sends no data. If a new train starts before the readout has finished, the old contents are thrown away and an error flag is raised.

Top module: `pix_ts_buf`

## Requirements
- R1: After reset, ts_valid_o, pwr_en_o, ovf_o and err_o are 0, the mask is clear and the block is idle.
- R2: pwr_en_o goes high in the cycle after train_start_i and stays high until the N_COLL-th (default 5000) collision strobe of that train has been taken. After that strobe it is 0.
- R3: A collision strobe with comp_i high stores the 0-based index of that collision within the train, from 0 to N_COLL-1 in a 13-bit word. comp_i is ignored on cycles with no collision strobe and on strobes where it is low.
- R4: At most DEPTH (default 16) timestamps are kept per train. A hit on a full store is dropped and sets ovf_o, which stays set until the next train_start_i clears it.
- R5: After rd_en_i in the dead time, the timestamps appear on ts_data_o with ts_valid_o in the order they were captured. A word is consumed on a cycle where ts_valid_o and rd_ready_i are both high. While rd_ready_i is low, ts_valid_o and ts_data_o hold their values.
- R6: The last word of a readout has ts_last_o=1 and is a marker. Bit 12 holds the overflow flag, bits 4:0 hold the number of stored timestamps, and bits 11:5 are 0. Data words have ts_last_o=0. ts_valid_o falls after the marker has been consumed.
- R7: ts_valid_o is never high while a train is being captured.
- R8: With the mask set, a train stores nothing, pwr_en_o stays 0, and rd_en_i produces no word.
- R9: A mask write (mask_we_i with value mask_val_i) takes effect only when the block is idle. A write during a train or a pending readout has no effect.
- R10: If train_start_i arrives while a readout is pending (data not yet fully drained), err_o is 1 from the next cycle and the earlier data are discarded. A train_start_i with nothing pending sets err_o back to 0.
- R11: Collision strobes outside a train do not move the collision counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| train_start_i | input | 1 | One-cycle strobe that opens a train |
| coll_i | input | 1 | One-cycle strobe for each collision |
| comp_i | input | 1 | Discriminator bit, sampled on coll_i |
| mask_we_i | input | 1 | Mask write strobe |
| mask_val_i | input | 1 | Mask value to write |
| rd_en_i | input | 1 | Start readout in the dead time |
| rd_ready_i | input | 1 | Consumer ready |
| ts_data_o | output | 13 | Timestamp or marker word |
| ts_valid_o | output | 1 | Word valid |
| ts_last_o | output | 1 | Marks the marker word |
| ovf_o | output | 1 | Sticky overflow for the current train |
| pwr_en_o | output | 1 | Comparator power enable |
| err_o | output | 1 | Previous readout was aborted by a train start |

## Verification
The hardest state to reach from the ports is a train start that lands in the middle of a readout. The stimulus drains only the first word of a directed train and then opens a new train with random hits. The readout that follows is checked against the new hit list only, together with err_o, and a later clean train must clear the error. Overflow also needs more than sixteen hits in a train, so one train uses a dense hit probability. The first and last collision indices are hit by directed trains, and those trains come after idle collision strobes and after comparator pulses that carry no strobe.

// File: rtl/pix_ts_pkg.sv
package pix_ts_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CAPT = 2'd1,
    ST_DONE = 2'd2,
    ST_READ = 2'd3
  } pix_st_e;
endpackage

// File: rtl/pix_coll_ctr.sv
module pix_coll_ctr #(
  parameter int unsigned TS_W   = 13,
  parameter int unsigned N_COLL = 5000
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            adv_i,
  output logic [TS_W-1:0] cnt_o,
  output logic            last_o
);
  localparam logic [TS_W-1:0] LAST_IDX = TS_W'(N_COLL - 1);

  logic [TS_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (adv_i) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign last_o = (cnt_q == LAST_IDX);
endmodule

// File: rtl/pix_ts_store.sv
module pix_ts_store #(
  parameter int unsigned TS_W  = 13,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1),
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             wr_i,
  input  logic [TS_W-1:0]  wr_data_i,
  input  logic [CNT_W-1:0] rd_idx_i,
  output logic [TS_W-1:0]  rd_data_o,
  output logic [CNT_W-1:0] count_o,
  output logic             full_o
);
  logic [TS_W-1:0]  mem_q [DEPTH];
  logic [CNT_W-1:0] count_q;
  logic             full;

  assign full = (count_q == CNT_W'(DEPTH));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            count_q <= '0;
    else if (clr_i)         count_q <= '0;
    else if (wr_i && !full) count_q <= count_q + 1'b1;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        mem_q[g] <= '0;
      else if (!clr_i && wr_i && count_q == CNT_W'(g))
        mem_q[g] <= wr_data_i;
    end
  end

  assign rd_data_o = mem_q[rd_idx_i[PTR_W-1:0]];
  assign count_o   = count_q;
  assign full_o    = full;
endmodule

// File: rtl/pix_ro_ser.sv
module pix_ro_ser #(
  parameter int unsigned TS_W  = 13,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1),
  localparam int unsigned PAD_W = TS_W - 1 - CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             active_i,
  input  logic             ready_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             ovf_i,
  input  logic [TS_W-1:0]  entry_i,
  output logic [CNT_W-1:0] rd_idx_o,
  output logic [TS_W-1:0]  data_o,
  output logic             valid_o,
  output logic             last_o,
  output logic             done_o
);
  logic [CNT_W-1:0] idx_q;
  logic             is_last;
  logic             take;

  assign is_last = (idx_q == count_i);
  assign take    = active_i && ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                idx_q <= '0;
    else if (start_i)           idx_q <= '0;
    else if (take && !is_last)  idx_q <= idx_q + 1'b1;
  end

  assign rd_idx_o = idx_q;
  assign valid_o  = active_i;
  assign last_o   = active_i && is_last;
  assign data_o   = is_last ? {ovf_i, {PAD_W{1'b0}}, count_i} : entry_i;
  assign done_o   = take && is_last;
endmodule

// File: rtl/pix_ts_buf.sv
module pix_ts_buf
  import pix_ts_pkg::*;
#(
  parameter int unsigned TS_W   = 13,
  parameter int unsigned N_COLL = 5000,
  parameter int unsigned DEPTH  = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            train_start_i,
  input  logic            coll_i,
  input  logic            comp_i,
  input  logic            mask_we_i,
  input  logic            mask_val_i,
  input  logic            rd_en_i,
  input  logic            rd_ready_i,
  output logic [TS_W-1:0] ts_data_o,
  output logic            ts_valid_o,
  output logic            ts_last_o,
  output logic            ovf_o,
  output logic            pwr_en_o,
  output logic            err_o
);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  pix_st_e          st_q, st_d;
  logic             mask_q, ovf_q, err_q;
  logic [TS_W-1:0]  coll_cnt;
  logic             coll_last;
  logic [CNT_W-1:0] fill_cnt, rd_idx;
  logic             full;
  logic [TS_W-1:0]  rd_entry;
  logic             ro_done;
  logic             capt, strobe_in_train, hit, ro_start, pend;

  assign capt            = (st_q == ST_CAPT);
  assign strobe_in_train = capt && coll_i && !train_start_i;
  assign hit             = strobe_in_train && comp_i && !mask_q;
  assign ro_start        = (st_q == ST_DONE) && rd_en_i && !train_start_i;
  assign pend            = (st_q == ST_DONE) || (st_q == ST_READ);

  always_comb begin
    st_d = st_q;
    if (train_start_i) begin
      st_d = ST_CAPT;
    end else begin
      unique case (st_q)
        ST_IDLE: st_d = ST_IDLE;
        ST_CAPT: if (coll_i && coll_last) st_d = mask_q ? ST_IDLE : ST_DONE;
        ST_DONE: if (rd_en_i) st_d = ST_READ;
        ST_READ: if (ro_done) st_d = ST_IDLE;
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      ovf_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (train_start_i) begin
        ovf_q <= 1'b0;
        err_q <= pend;
      end else if (hit && full) begin
        ovf_q <= 1'b1;
      end
    end
  end

  // configuration write only accepted between activities
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)
      mask_q <= 1'b0;
    else if (mask_we_i && st_q == ST_IDLE && !train_start_i)
      mask_q <= mask_val_i;
  end

  pix_coll_ctr #(.TS_W(TS_W), .N_COLL(N_COLL)) u_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (train_start_i),
    .adv_i  (strobe_in_train),
    .cnt_o  (coll_cnt),
    .last_o (coll_last)
  );

  pix_ts_store #(.TS_W(TS_W), .DEPTH(DEPTH)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (train_start_i),
    .wr_i      (hit),
    .wr_data_i (coll_cnt),
    .rd_idx_i  (rd_idx),
    .rd_data_o (rd_entry),
    .count_o   (fill_cnt),
    .full_o    (full)
  );

  pix_ro_ser #(.TS_W(TS_W), .DEPTH(DEPTH)) u_ser (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (ro_start),
    .active_i (st_q == ST_READ),
    .ready_i  (rd_ready_i),
    .count_i  (fill_cnt),
    .ovf_i    (ovf_q),
    .entry_i  (rd_entry),
    .rd_idx_o (rd_idx),
    .data_o   (ts_data_o),
    .valid_o  (ts_valid_o),
    .last_o   (ts_last_o),
    .done_o   (ro_done)
  );

  assign ovf_o    = ovf_q;
  assign err_o    = err_q;
  assign pwr_en_o = capt && !mask_q;
endmodule

// File: rtl/pix_ts_buf_chk.sv
module pix_ts_buf_chk #(
  parameter int unsigned TS_W  = 13,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             train_start_i,
  input logic             rd_ready_i,
  input logic [TS_W-1:0]  ts_data_o,
  input logic             ts_valid_o,
  input logic             ts_last_o,
  input logic             ovf_o,
  input logic             pwr_en_o,
  input logic             err_o,
  input logic             mask_q,
  input logic [CNT_W-1:0] fill_cnt
);
  p_no_valid_in_train_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_en_o |-> !ts_valid_o);

  p_hold_on_stall_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ts_valid_o && !rd_ready_i && !train_start_i |=>
      ts_valid_o && $stable(ts_data_o) && $stable(ts_last_o));

  p_masked_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_q |-> !ts_valid_o && !pwr_en_o);

  p_ovf_needs_full_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_o) |-> fill_cnt == CNT_W'(DEPTH));

  p_ovf_cleared_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    train_start_i |=> !ovf_o);

  p_abort_flags_err_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    train_start_i && ts_valid_o |=> err_o && !ts_valid_o);

  p_mask_frozen_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_en_o || ts_valid_o) && !train_start_i |=> $stable(mask_q));
endmodule

bind pix_ts_buf pix_ts_buf_chk #(.TS_W(TS_W), .DEPTH(DEPTH)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .train_start_i (train_start_i),
  .rd_ready_i    (rd_ready_i),
  .ts_data_o     (ts_data_o),
  .ts_valid_o    (ts_valid_o),
  .ts_last_o     (ts_last_o),
  .ovf_o         (ovf_o),
  .pwr_en_o      (pwr_en_o),
  .err_o         (err_o),
  .mask_q        (mask_q),
  .fill_cnt      (fill_cnt)
);

// File: tb/pix_ts_buf_tb_top.sv
module pix_ts_buf_tb_top;
  localparam int N_COLL = 5000;
  localparam int DEPTH  = 16;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n, train_start, coll, comp, mask_we, mask_val, rd_en, rd_ready;
  logic [12:0] ts_data;
  logic        ts_valid, ts_last, ovf, pwr_en, err;

  pix_ts_buf dut_i (
    .clk_i(clk), .rst_ni(rst_n), .train_start_i(train_start), .coll_i(coll),
    .comp_i(comp), .mask_we_i(mask_we), .mask_val_i(mask_val), .rd_en_i(rd_en),
    .rd_ready_i(rd_ready), .ts_data_o(ts_data), .ts_valid_o(ts_valid),
    .ts_last_o(ts_last), .ovf_o(ovf), .pwr_en_o(pwr_en), .err_o(err)
  );

  int checks = 0;
  int errors = 0;
  bit ended  = 0;
  int exp_q[$];
  bit exp_ovf;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int marker(input int n, input bit o);
    return (int'(o) << 12) | n;
  endfunction

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic run_train(input int per_mille, input bit directed, input bit masked,
                           input int poke, input bit exp_err);
    int bad = 0;
    bit h;
    @(negedge clk); train_start = 1;
    @(negedge clk); train_start = 0;
    exp_q.delete(); exp_ovf = 0;
    chk(pwr_en == !masked, "R2 power on at train start", pwr_en, !masked);
    chk(!ovf, "R4 overflow cleared by train start", ovf, 0);
    chk(err == exp_err, "R10 error flag at train start", err, exp_err);
    for (int c = 0; c < N_COLL; c++) begin
      h = directed ? (c == 0 || c == 2500 || c == N_COLL - 1)
                   : ($urandom_range(999) < per_mille);
      coll = 1; comp = h;
      if (c == 100 && poke >= 0) begin mask_we = 1; mask_val = poke[0]; end
      @(negedge clk);
      coll = 0; comp = 0; mask_we = 0;
      if (c < N_COLL - 1 && (pwr_en != !masked || ts_valid)) bad++;
      if (h && !masked) begin
        if (exp_q.size() < DEPTH) exp_q.push_back(c);
        else exp_ovf = 1;
      end
      if ($urandom_range(3) == 0) begin
        comp = $urandom_range(1);   // comparator noise with no strobe
        @(negedge clk);
        comp = 0;
        if (c < N_COLL - 1 && (pwr_en != !masked || ts_valid)) bad++;
      end
    end
    chk(bad == 0, "R7 no valid and steady power in train", bad, 0);
    chk(!pwr_en, "R2 power off after last collision", pwr_en, 0);
    chk(ovf == exp_ovf, "R4 overflow flag after train", ovf, exp_ovf);
  endtask

  task automatic read_out(input int max_words);
    int idx = 0;
    int n = 0;
    bit done = 0;
    bit stalled = 0;
    logic [12:0] held;
    bit r;
    @(negedge clk); rd_en = 1;
    @(negedge clk); rd_en = 0;
    while (!done && n < 4000) begin
      if (stalled)
        chk(ts_valid && ts_data == held, "R5 word held while stalled", ts_data, held);
      r = ($urandom_range(2) != 0);
      rd_ready = r;
      stalled = ts_valid && !r;
      held = ts_data;
      if (ts_valid && r) begin
        if (idx < exp_q.size())
          chk(!ts_last && int'(ts_data) == exp_q[idx], "R5 R3 timestamp order", ts_data, exp_q[idx]);
        else begin
          chk(ts_last && int'(ts_data) == marker(exp_q.size(), exp_ovf),
              "R6 marker word", ts_data, marker(exp_q.size(), exp_ovf));
          done = 1;
        end
        idx++;
        if (idx >= max_words) done = 1;
      end
      @(negedge clk);
      n++;
    end
    rd_ready = 0;
    chk(done, "R5 readout completed", done, 1);
    if (idx > exp_q.size()) chk(!ts_valid, "R6 valid drops after marker", ts_valid, 0);
  endtask

  task automatic set_mask(input bit v);
    @(negedge clk); mask_we = 1; mask_val = v;
    @(negedge clk); mask_we = 0;
  endtask

  task automatic expect_quiet(input string req);
    int seen = 0;
    @(negedge clk); rd_en = 1;
    @(negedge clk); rd_en = 0; rd_ready = 1;
    for (int i = 0; i < 20; i++) begin
      if (ts_valid) seen++;
      @(negedge clk);
    end
    rd_ready = 0;
    chk(seen == 0, req, seen, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual 1 expected 0");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst_n = 0; train_start = 0; coll = 0; comp = 0;
    mask_we = 0; mask_val = 0; rd_en = 0; rd_ready = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!ts_valid && !pwr_en && !ovf && !err, "R1 reset state",
        {ts_valid, pwr_en, ovf, err}, 0);
    expect_quiet("R1 nothing to read after reset");

    // R11: idle strobes must not move the counter
    for (int i = 0; i < 7; i++) begin
      @(negedge clk); coll = 1; comp = 1;
      @(negedge clk); coll = 0; comp = 0;
    end
    run_train(0, 1, 0, -1, 0);
    chk(exp_q.size() == 3, "R11 directed hits", exp_q.size(), 3);
    read_out(100);

    run_train(3, 0, 0, -1, 0);   // sparse
    read_out(100);
    run_train(30, 0, 0, -1, 0);  // dense, expected to overflow
    chk(ovf == 1, "R4 dense train overflows", ovf, 1);
    read_out(100);
    run_train(0, 0, 0, -1, 0);   // empty train
    read_out(100);

    // R9: mask write mid-train ignored, data still recorded
    run_train(0, 1, 0, 1, 0);
    read_out(100);

    // R8 masked pixel, R9 clearing write mid-train ignored
    set_mask(1);
    run_train(30, 0, 1, 0, 0);
    expect_quiet("R8 masked pixel sends nothing");
    run_train(30, 0, 1, -1, 0);
    expect_quiet("R9 mask still set after ignored write");
    set_mask(0);

    // R10: abort a partial readout
    run_train(0, 1, 0, -1, 0);
    read_out(1);
    run_train(5, 0, 0, -1, 1);
    read_out(100);
    run_train(0, 1, 0, -1, 0);   // clean start clears err
    read_out(100);

    finish_run();
  end
endmodule